// File: doc/BRIEF.md
# Two-Instruction-Per-Word Accumulator Processor

This block is a small multicycle processor built around a single accumulator. Memory words are 40 bits wide and each one carries two 20-bit instructions. The left-hand instruction sits in the upper half and the right-hand one in the lower half. Every instruction has an 8-bit opcode in its upper bits and a 12-bit address below it. The core supports four kinds of operation: copy a memory word into the accumulator, copy the two's-complement negative of a memory word into the accumulator, write the accumulator to memory, and jump on a nonnegative accumulator. Any other opcode stops the machine.

The core connects to a word-wide synchronous memory. It has one address bus, a write-data bus, a read-data bus, and separate one-cycle read and write strobes. All traffic passes through two registers. The memory address register always drives the address bus, and the memory buffer register receives every word that is read and supplies every word that is written.

When a word is fetched, its left half runs first and its right half is held in an instruction buffer. The right half then runs without a second fetch, and only after that does the program counter advance. A taken jump drops whatever is buffered. The jump opcode selects whether execution resumes at the left or the right half of the target word.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, mem_rd, mem_wr and halted are all low. After reset releases, the first read is the instruction fetch at the address given by the START_PC parameter, and the accumulator holds 0.
- R2: Each fetched word runs its left half (bits 39:20) first and then its right half (bits 19:0) with no second fetch. The program counter then advances by one.
- R3: Opcode 0x01 copies the word at its address field (bits 11:0) into the accumulator. Counting the instruction fetch, it costs two memory reads.
- R4: Opcode 0x02 puts the 40-bit two's-complement negative of the addressed word into the accumulator.
- R5: Opcode 0x21 raises mem_wr for exactly one cycle, with mem_addr equal to the address field and mem_wdata equal to the accumulator.
- R6: Opcode 0x0F continues at the left half of the addressed word when accumulator bit 39 is 0, which includes a zero accumulator. Otherwise execution falls through to the next instruction in order.
- R7: Opcode 0x10 continues at the right half of the addressed word under the same condition as R6. The left half of that word does not run, and the program counter advances after the right half.
- R8: When a jump in a left half is taken, the buffered right half of the same word is discarded and never runs.
- R9: Any opcode other than 0x01, 0x02, 0x21, 0x0F and 0x10 raises halted. Once halted is high it stays high, and no further read or write strobe appears.
- R10: Read data is taken one clock after the read strobe. mem_rd and mem_wr are never high together, and each strobe lasts a single cycle.
- R11: The program 0x08A: {01 0FA, 21 0FB}, 0x08B: {01 0FA, 0F 08D}, 0x08C: {02 0FA, 21 0FB} leaves the absolute value of word 0x0FA in word 0x0FB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| mem_addr | output | ADDR_W | Address bus, always the memory address register |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata one clock later |
| mem_wr | output | 1 | Write strobe; memory captures mem_wdata at mem_addr |
| mem_wdata | output | WORD_W | Write data, always the memory buffer register |
| mem_rdata | input | WORD_W | Read data returned by the memory |
| halted | output | 1 | High once an unsupported opcode has been decoded |

## Verification
The bench drives the absolute-value program with a positive, a negative and a zero operand. The zero case is the trap for a sign test that treats zero as negative: such a design would fall through and write a second, wrong store. Several programs target the right half of a word:
- A right-half jump target. If the design ran the left half as well, an extra store would reach a sentinel word.
- A taken jump sitting in a left half. If the design kept the buffered right half, its store would still appear.
- An unsupported opcode in the very first instruction.

For every program the bench also counts the read strobes, so a core that refetched the word for its right half, or kept fetching after halting, shows the wrong read count.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OPC_NLOAD = 8'h02;
  localparam logic [OPC_W-1:0] OPC_STORE = 8'h21;
  localparam logic [OPC_W-1:0] OPC_JMPL  = 8'h0F;
  localparam logic [OPC_W-1:0] OPC_JMPR  = 8'h10;

  typedef enum logic [2:0] {
    K_LOAD,
    K_NLOAD,
    K_STORE,
    K_JUMPL,
    K_JUMPR,
    K_BAD
  } op_kind_t;

  typedef enum logic [3:0] {
    S_FADDR,
    S_FREAD,
    S_FLATCH,
    S_SPLIT,
    S_EXEC,
    S_OREAD,
    S_OLATCH,
    S_OAPPLY,
    S_WRITE,
    S_NEXT,
    S_HALT
  } cpu_state_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_kind_t         kind
);

  always_comb begin
    unique case (opcode)
      OPC_LOAD:  kind = K_LOAD;
      OPC_NLOAD: kind = K_NLOAD;
      OPC_STORE: kind = K_STORE;
      OPC_JMPL:  kind = K_JUMPL;
      OPC_JMPR:  kind = K_JUMPR;
      default:   kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_kind_t   kind,
  input  logic       ac_neg,
  input  logic       ibr_valid,
  output cpu_state_t state
);

  cpu_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      S_FADDR:  state_d = S_FREAD;
      S_FREAD:  state_d = S_FLATCH;
      S_FLATCH: state_d = S_SPLIT;
      S_SPLIT:  state_d = S_EXEC;
      S_EXEC: begin
        unique case (kind)
          K_LOAD, K_NLOAD:  state_d = S_OREAD;
          K_STORE:          state_d = S_WRITE;
          K_JUMPL, K_JUMPR: state_d = ac_neg ? S_NEXT : S_FADDR;
          default:          state_d = S_HALT;
        endcase
      end
      S_OREAD:  state_d = S_OLATCH;
      S_OLATCH: state_d = S_OAPPLY;
      S_OAPPLY: state_d = S_NEXT;
      S_WRITE:  state_d = S_NEXT;
      S_NEXT:   state_d = ibr_valid ? S_EXEC : S_FADDR;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FADDR;
    else        state <= state_d;
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int          WORD_W      = 40,
  parameter int          ADDR_W      = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [11:0] START_PC    = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted
);

  localparam int INSN_W = OPC_W + ADDR_W;

  // reset release synchroniser
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   core_rst_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign core_rst_n = rst_pipe[SYNC_STAGES-1];

  // architectural registers
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [WORD_W-1:0] mbr_q, mbr_d;
  logic [WORD_W-1:0] ac_q, ac_d;
  logic [INSN_W-1:0] ir_q, ir_d;
  logic [INSN_W-1:0] ibr_q, ibr_d;
  logic              ibr_vld_q, ibr_vld_d;
  logic              right_q, right_d;

  logic [OPC_W-1:0]  ir_opc;
  logic [ADDR_W-1:0] ir_addr;
  op_kind_t          kind;
  cpu_state_t        state;
  logic              ac_neg;
  logic              jump_kind;

  assign ir_opc    = ir_q[INSN_W-1:ADDR_W];
  assign ir_addr   = ir_q[ADDR_W-1:0];
  assign ac_neg    = ac_q[WORD_W-1];
  assign jump_kind = (kind == K_JUMPL) || (kind == K_JUMPR);

  acc_decode u_dec (
    .opcode (ir_opc),
    .kind   (kind)
  );

  acc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .kind      (kind),
    .ac_neg    (ac_neg),
    .ibr_valid (ibr_vld_q),
    .state     (state)
  );

  // datapath next-state
  always_comb begin
    pc_d      = pc_q;
    mar_d     = mar_q;
    mbr_d     = mbr_q;
    ac_d      = ac_q;
    ir_d      = ir_q;
    ibr_d     = ibr_q;
    ibr_vld_d = ibr_vld_q;
    right_d   = right_q;
    unique case (state)
      S_FADDR: mar_d = pc_q;
      S_FLATCH: mbr_d = mem_rdata;
      S_SPLIT: begin
        if (right_q) begin
          ir_d      = mbr_q[INSN_W-1:0];
          ibr_vld_d = 1'b0;
        end else begin
          ir_d      = mbr_q[WORD_W-1 -: INSN_W];
          ibr_d     = mbr_q[INSN_W-1:0];
          ibr_vld_d = 1'b1;
        end
      end
      S_EXEC: begin
        mar_d = ir_addr;
        if (kind == K_STORE) mbr_d = ac_q;
        if (jump_kind && !ac_neg) begin
          pc_d      = ir_addr;
          right_d   = (kind == K_JUMPR);
          ibr_vld_d = 1'b0;
        end
      end
      S_OLATCH: mbr_d = mem_rdata;
      S_OAPPLY: ac_d = (kind == K_NLOAD) ? (WORD_W'(0) - mbr_q) : mbr_q;
      S_NEXT: begin
        if (ibr_vld_q) begin
          ir_d      = ibr_q;
          ibr_vld_d = 1'b0;
        end else begin
          pc_d    = pc_q + ADDR_W'(1);
          right_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  // datapath registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q      <= START_PC[ADDR_W-1:0];
      mar_q     <= '0;
      mbr_q     <= '0;
      ac_q      <= '0;
      ir_q      <= '0;
      ibr_q     <= '0;
      ibr_vld_q <= 1'b0;
      right_q   <= 1'b0;
    end else begin
      pc_q      <= pc_d;
      mar_q     <= mar_d;
      mbr_q     <= mbr_d;
      ac_q      <= ac_d;
      ir_q      <= ir_d;
      ibr_q     <= ibr_d;
      ibr_vld_q <= ibr_vld_d;
      right_q   <= right_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = (state == S_FREAD) || (state == S_OREAD);
  assign mem_wr    = (state == S_WRITE);
  assign halted    = (state == S_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_rd,
  input logic mem_wr,
  input logic halted
);

  a_r10_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r10_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r5_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

endmodule

bind acc_cpu acc_cpu_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .halted (halted)
);

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [39:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  acc_cpu #(.START_PC(12'h08A)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // synchronous memory model
  logic [39:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  logic [11:0] first_rd;
  logic        seen_rd = 1'b0;

  typedef struct packed { logic [11:0] a; logic [39:0] d; } wr_t;
  wr_t exp_q[$];
  wr_t popped;

  localparam logic [39:0] SENT = 40'hA5A5_5A5A_C3;

  function automatic logic [39:0] word(logic [7:0] lo, logic [11:0] la,
                                       logic [7:0] ro, logic [11:0] ra);
    return {lo, la, ro, ra};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_wr(logic [11:0] a, logic [39:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = SENT;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (!seen_rd) begin
          first_rd = mem_addr;
          seen_rd  = 1'b1;
        end
        rd_count++;
      end
      if (mem_rd && mem_wr) check("R10 strobes overlap", 1, 0);
      if (mem_wr) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R5 unexpected write: got %0h@%0h expected none", mem_wdata, mem_addr);
        end else begin
          popped = exp_q.pop_front();
          check("R5 write address", mem_addr, popped.a);
          check("R5 write data", mem_wdata, popped.d);
        end
      end
    end
  end

  task automatic run(string tag, int exp_reads);
    int n;
    int r0;
    n = 0;
    rst_n = 1'b0;
    rd_count = 0;
    seen_rd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({"R1 reset strobes ", tag}, {mem_rd, mem_wr, halted}, 0);
    rst_n = 1'b1;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check({"R9 halt reached ", tag}, halted, 1);
    check({"R1 first fetch ", tag}, first_rd, 12'h08A);
    check({"R2 R3 read count ", tag}, rd_count, exp_reads);
    check({"R5 pending writes ", tag}, exp_q.size(), 0);
    r0 = rd_count;
    repeat (20) @(negedge clk);
    check({"R9 quiet after halt ", tag}, {rd_count, 31'd0, halted}, {r0, 31'd0, 1'b1});
  endtask

  task automatic load_abs(logic [39:0] x);
    clear_mem();
    mem[8'h8A] = word(8'h01, 12'h0FA, 8'h21, 12'h0FB);
    mem[8'h8B] = word(8'h01, 12'h0FA, 8'h0F, 12'h08D);
    mem[8'h8C] = word(8'h02, 12'h0FA, 8'h21, 12'h0FB);
    mem[8'h8D] = 40'h0;
    mem[8'hFA] = x;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 positive operand: jump taken, single store
    load_abs(40'd12345);
    expect_wr(12'h0FB, 40'd12345);
    run("abs positive", 5);
    check("R11 abs positive result", mem[8'hFB], 40'd12345);

    // R11 R4 R6 negative operand: fall through, negated store
    load_abs(40'hFF_FFFF_FFF9);
    expect_wr(12'h0FB, 40'hFF_FFFF_FFF9);
    expect_wr(12'h0FB, 40'd7);
    run("abs negative", 7);
    check("R11 R4 abs negative result", mem[8'hFB], 40'd7);

    // R6 zero is nonnegative
    load_abs(40'd0);
    expect_wr(12'h0FB, 40'd0);
    run("abs zero", 5);
    check("R6 zero result", mem[8'hFB], 40'd0);

    // R7 jump into right half skips left half
    clear_mem();
    mem[8'h8A] = word(8'h01, 12'h0F0, 8'h10, 12'h090);
    mem[8'h90] = word(8'h21, 12'h0F1, 8'h21, 12'h0F2);
    mem[8'h91] = 40'h0;
    mem[8'hF0] = 40'd5;
    expect_wr(12'h0F2, 40'd5);
    run("jump right", 4);
    check("R7 left half skipped", mem[8'hF1], SENT);
    check("R3 R7 right half stored", mem[8'hF2], 40'd5);

    // R7 not taken on negative accumulator
    clear_mem();
    mem[8'h8A] = word(8'h01, 12'h0F0, 8'h10, 12'h090);
    mem[8'h8B] = word(8'h21, 12'h0F3, 8'h00, 12'h000);
    mem[8'h90] = word(8'h21, 12'h0F1, 8'h21, 12'h0F2);
    mem[8'hF0] = 40'h80_0000_0001;
    expect_wr(12'h0F3, 40'h80_0000_0001);
    run("jump right not taken", 3);
    check("R7 target untouched", mem[8'hF2], SENT);

    // R8 R11 taken left jump discards buffered right; accumulator is 0
    clear_mem();
    mem[8'h8A] = word(8'h0F, 12'h08C, 8'h21, 12'h0F1);
    mem[8'h8C] = word(8'h21, 12'h0F2, 8'h00, 12'h000);
    expect_wr(12'h0F2, 40'd0);
    run("discard buffer", 2);
    check("R8 buffered store dropped", mem[8'hF1], SENT);
    check("R1 reset accumulator", mem[8'hF2], 40'd0);

    // R9 unsupported opcode in the first instruction
    clear_mem();
    mem[8'h8A] = word(8'h0B, 12'h0F0, 8'h21, 12'h0F1);
    run("bad opcode", 1);
    check("R9 right half not run", mem[8'hF1], SENT);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule